// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands of `N` bits each and returns the full `2N`-bit product, with `N` chosen at elaboration (default 4, usable from 2 to 8). Every partial-product bit is a plain AND of one bit of `a` with one bit of `b`. The array of partial products is then reduced row by row with full adders whose carries are not passed along the row. Each carry drops diagonally into the next row, one column to the left. The lowest product bits fall out of the rows directly. A single closing adder row, in which carries do ripple, merges the leftover sum and carry vectors into the upper half of the product.

In a ripple array the carry chain runs inside every row. Here it runs only once, at the bottom, so the longest path is 6 full-adder delays for 4x4 and 14 for 8x8, against 8 and 20 for a ripple array. The merged product is captured in one output register, so the result appears one clock after the operands are sampled.

Top module: `csa_array_mult`

## Requirements
- R1: On every rising clock edge with `rst_n` high, `product` is loaded with the unsigned product of the `a` and `b` values present at that edge, all `2N` bits kept (example for N = 4: 5 x 7 gives 8'd35).
- R2: While `rst_n` is low, `product` is held at zero, asynchronously, and it remains zero until the first edge after release.
- R3: Bit 0 of `product` equals `a[0] AND b[0]` of the operands captured.
- R4: If either captured operand is zero, the registered product is zero.
- R5: If the captured `b` is 1, the registered product equals the captured `a` extended with zeros.
- R6: The largest operands give the largest product with no truncation: (2^N-1)^2, which is 8'd225 for N = 4 and 16'd65025 for N = 8.
- R7: Bit `2N-1` of `product` is set only when bit `N-1` of both captured operands is set.
- R8: The same behaviour holds for every operand pair at N = 4 and for N = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands are sampled and the product is loaded on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the product register |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| product | output | 2N | Registered unsigned product a x b |

## Verification
The assertions check on every cycle that the registered product matches the product of the previous cycle's operands. They also check the low-bit AND, the zero and unit-operand shortcuts, the top-bit rule and the clear state after reset. Together these cover the arithmetic of the carry-save rows and the merge row for whatever values arrive. Only the bench's scenarios show that every column and carry path has actually been driven. That takes a sweep of all 256 operand pairs at N = 4, the extreme corners and a random run at N = 8. The bench also confirms the one-cycle latency as seen at the ports.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_res_t;

    function automatic fa_res_t fa_eval(input logic x, input logic y, input logic ci);
        fa_res_t r;
        r.sum   = x ^ y ^ ci;
        r.carry = (x & y) | (x & ci) | (y & ci);
        return r;
    endfunction

endpackage

// File: rtl/csa_fa.sv
module csa_fa
    import csa_mul_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    fa_res_t res;

    always_comb begin
        res = fa_eval(x, y, ci);
        s   = res.sum;
        co  = res.carry;
    end
endmodule

// File: rtl/csa_pp_gen.sv
module csa_pp_gen #(
    parameter int N = 4
) (
    input  logic [N-1:0]         a,
    input  logic [N-1:0]         b,
    output logic [N-1:0][N-1:0]  pp   // pp[j][i] = a[i] & b[j], weight i+j
);
    for (genvar j = 0; j < N; j++) begin : g_row
        for (genvar i = 0; i < N; i++) begin : g_col
            assign pp[j][i] = a[i] & b[j];
        end
    end
endmodule

// File: rtl/csa_save_rows.sv
module csa_save_rows #(
    parameter int N = 4
) (
    input  logic [N-1:0][N-1:0] pp,
    output logic [N-1:0]        low_bits,  // product bits 0 .. N-1
    output logic [N-2:0]        sum_left,  // leftover sums, weights N .. 2N-2
    output logic [N-1:0]        carry_left // leftover carries, weights N .. 2N-1
);
    // s_row[j][i] and c_row[j][i] belong to row j, cell i (weight i+j)
    logic [N-1:0][N-1:0] s_row;
    logic [N-1:0][N-1:0] c_row;

    // row 0: partial products alone, carry-in vector tied to zero
    assign s_row[0] = pp[0];
    assign c_row[0] = '0;

    for (genvar j = 1; j < N; j++) begin : g_row
        for (genvar i = 0; i < N; i++) begin : g_cell
            logic y_in;
            if (i == N - 1) begin : g_edge
                assign y_in = 1'b0;
            end else begin : g_inner
                assign y_in = s_row[j-1][i+1];
            end
            csa_fa u_fa (
                .x  (pp[j][i]),
                .y  (y_in),
                .ci (c_row[j-1][i]),
                .s  (s_row[j][i]),
                .co (c_row[j][i])
            );
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_low
        assign low_bits[j] = s_row[j][0];
    end

    assign sum_left   = s_row[N-1][N-1:1];
    assign carry_left = c_row[N-1];
endmodule

// File: rtl/csa_merge_row.sv
module csa_merge_row #(
    parameter int N = 4
) (
    input  logic [N-2:0] sum_left,
    input  logic [N-1:0] carry_left,
    output logic [N-1:0] high_bits   // product bits N .. 2N-1
);
    logic [N-1:0] rc;   // ripple carry into each column of this row
    assign rc[0] = 1'b0;

    for (genvar k = 0; k < N - 1; k++) begin : g_col
        csa_fa u_fa (
            .x  (sum_left[k]),
            .y  (carry_left[k]),
            .ci (rc[k]),
            .s  (high_bits[k]),
            .co (rc[k+1])
        );
    end

    // top column: no sum input remains, and its carry-out is always zero
    assign high_bits[N-1] = carry_left[N-1] ^ rc[N-1];
endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] product
);
    localparam int P_W = 2 * N;

    typedef struct packed {
        logic [P_W-1:0] prod;
    } mult_state_t;

    logic [N-1:0][N-1:0] pp;
    logic [N-1:0]        low_bits;
    logic [N-2:0]        sum_left;
    logic [N-1:0]        carry_left;
    logic [N-1:0]        high_bits;

    mult_state_t st_d, st_q;

    csa_pp_gen #(.N(N)) u_pp (
        .a  (a),
        .b  (b),
        .pp (pp)
    );

    csa_save_rows #(.N(N)) u_rows (
        .pp         (pp),
        .low_bits   (low_bits),
        .sum_left   (sum_left),
        .carry_left (carry_left)
    );

    csa_merge_row #(.N(N)) u_merge (
        .sum_left   (sum_left),
        .carry_left (carry_left),
        .high_bits  (high_bits)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prod = {high_bits, low_bits};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign product = st_q.prod;
endmodule

// File: rtl/csa_array_mult_chk.sv
module csa_array_mult_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   a,
    input logic [N-1:0]   b,
    input logic [2*N-1:0] product
);
    logic [2*N-1:0] a_w, b_w;
    assign a_w = {{N{1'b0}}, a};
    assign b_w = {{N{1'b0}}, b};

    // R2: product is clear on the first edge after reset release
    p_reset_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> product == '0);

    // R1, R6, R8: full-width product of the previous operands
    p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> product == $past(a_w) * $past(b_w));

    p_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> product[0] == ($past(a[0]) & $past(b[0])));

    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(a) == '0 || $past(b) == '0)) |-> product == '0);

    p_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(b) == N'(1)) |-> product == $past(a_w));

    p_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && product[2*N-1]) |-> ($past(a[N-1]) && $past(b[N-1])));
endmodule

bind csa_array_mult csa_array_mult_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a       (a),
    .b       (b),
    .product (product)
);

// File: tb/sim_csa_array_mult.sv
module sim_csa_array_mult;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [7:0]  p4;
    logic [15:0] p8;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    csa_array_mult #(.N(4)) u0 (.clk(clk), .rst_n(rst_n), .a(a4), .b(b4), .product(p4));
    csa_array_mult #(.N(8)) u1 (.clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .product(p8));

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // drive both instances, wait one edge, compare with behavioural expectations
    task automatic step(input int x4, input int y4, input int x8, input int y8, input string tag);
        int e4, e8;
        a4 = 4'(x4); b4 = 4'(y4);
        a8 = 8'(x8); b8 = 8'(y8);
        e4 = (x4 % 16) * (y4 % 16);
        e8 = (x8 % 256) * (y8 % 256);
        @(posedge clk); #1;
        check({tag, " N=4"}, int'(p4), e4);
        check({tag, " N=8"}, int'(p8), e8);
        check("R3 bit0 N=4", int'(p4[0]), (x4 & y4) & 1);
        if (p8[15]) check("R7 msb N=8", int'(a8[7] & b8[7]), 1);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        a4 = 4'd9; b4 = 4'd7; a8 = 8'd200; b8 = 8'd3;
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset N=4", int'(p4), 0);
        check("R2 reset N=8", int'(p8), 0);
        a4 = '0; b4 = '0; a8 = '0; b8 = '0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R2 after release N=4", int'(p4), 0);

        step(5, 7, 5, 7, "R1 five times seven");
        step(0, 13, 0, 250, "R4 zero a");
        step(11, 0, 177, 0, "R4 zero b");
        step(9, 1, 201, 1, "R5 times one");
        step(15, 15, 255, 255, "R6 max");
        step(8, 8, 128, 128, "R7 msb both");
        step(15, 7, 255, 127, "R7 msb one");

        // R8: every pair at N = 4, random pairs at N = 8 alongside
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                step(x, y, $urandom_range(255), $urandom_range(255), "R8 sweep");
            end
        end
        for (int k = 0; k < 1500; k++) begin
            step($urandom_range(15), $urandom_range(15),
                 $urandom_range(255), $urandom_range(255), "R8 random");
        end

        // R2: reset mid-run clears the product asynchronously
        a4 = 4'd13; b4 = 4'd11; a8 = 8'd99; b8 = 8'd77;
        #1 rst_n = 1'b0;
        #1;
        check("R2 async clear N=4", int'(p4), 0);
        check("R2 async clear N=8", int'(p8), 0);
        finish_run();
    end
endmodule